// File: doc/BRIEF.md
# Multi-Source System Reset Generator

This block drives the internal system reset of a small low-power controller. Two sources can start it. The first is an active-low reset pin. A low level on the pin sets a reset-holding register at once, without waiting for a clock edge. The second is a chord: a chosen set of the four active-low key inputs held low together. The chord is debounced by a sample counter and can also be required to last through a long-press window of one to two seconds.

Every input is brought into the low-frequency clock domain through two flops before any filtering is applied. A free-running divider, started when the oscillator-running flag rises, supplies the half-second phase and the one-second tick. The reset is released only at a clock edge where the synchronised pin is high and the half-second phase is high. After the pin rises, release can therefore take up to a quarter of the divider period.

The chord selection, the long-press option, the divider length and the debounce length are all build-time parameters.

Top module: `sysrst_gen`

## Requirements
- R1: While `rst_pin_n` is low, `sys_rst` is 1. It goes to 1 asynchronously, so a low pulse shorter than one clock period is caught and held.
- R2: `sys_rst` falls only at a clock edge where the divider phase bit (bit DIV_LOG2-2 of a counter holding the number of edges since `osc_run` rose) is 1 before that edge and the synchronised pin is high. The fall comes 3 to 2^(DIV_LOG2-2)+4 edges after the pin rises.
- R3: A chord is present when every key in the selected mask reads low. KEY_SEL=1 selects `key_n` bits 0..3, KEY_SEL=2 selects bits 0..2 and KEY_SEL=3 selects bits 0..1. The unselected keys may take any level.
- R4: With KEY_SEL=0 the key path never raises `sys_rst`, whatever the key pattern.
- R5: Without long-press, a chord held for NR_CYCLES+1 clock periods or more raises `sys_rst` at the (NR_CYCLES+3)th edge after it is applied. A chord held for only NR_CYCLES periods has no effect.
- R6: With HOLD_EN=1, `sys_rst` rises no earlier than 2^DIV_LOG2 edges and no later than 2^(DIV_LOG2+1)+NR_CYCLES+4 edges after the chord is applied.
- R7: A single sampled high level in the chord restarts both the debounce count and the long-press count.
- R8: While `osc_run` is low, the key path stays idle. The debounce count begins when `osc_run` rises.
- R9: Once the key path has raised `sys_rst`, the reset holds while the chord is held. After the chord ends, the reset is released under the rule of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Low-frequency clock |
| osc_run | input | 1 | High once the oscillator runs; low clears the divider and the key filter |
| rst_pin_n | input | 1 | Active-low external reset pin |
| key_n | input | 4 | Active-low key inputs 0..3 |
| sys_rst | output | 1 | Active-high internal system reset |

## Verification
Inputs change at falling edges. A key chord reaches the filter after two synchroniser edges. The filter output sets the reset one edge after the debounce count completes. The bench therefore samples a chord held for L periods just after the (L+2)th rising edge, which is the last edge at which the chord can still set the reset.

The pin asserts the reset with no clock, so the bench checks it half a nanosecond after a sub-cycle pulse. For release, the bench counts edges from the oscillator start in its own counter. It checks that the phase bit was set on the release edge and that the delay from the pin rising lies between 3 edges and a quarter divider period plus 4. Long-press timing is checked against a window, since the tick phase at the moment of the press varies.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
   localparam int KEYS = 4;

   // chord masks per selection code; 0 = key path disabled
   function automatic logic [KEYS-1:0] chord_mask(input int sel);
      case (sel)
         1:       chord_mask = 4'b1111;
         2:       chord_mask = 4'b0111;
         3:       chord_mask = 4'b0011;
         default: chord_mask = 4'b0000;
      endcase
   endfunction
endpackage

// File: rtl/sysrst_div.sv
module sysrst_div #(
   parameter int DIV_LOG2 = 15
) (
   input  logic clk,
   input  logic osc_run,
   output logic ph2,
   output logic sec_tick
);
   localparam int W = DIV_LOG2;

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge osc_run) begin
      if (!osc_run) cnt <= '0;
      else          cnt <= cnt + W'(1);
   end

   // half-second phase and the edge at which the one-second bit rises
   assign ph2      = cnt[W-2];
   assign sec_tick = (&cnt[W-2:0]) & ~cnt[W-1];
endmodule

// File: rtl/sysrst_keyfilt.sv
module sysrst_keyfilt
   import sysrst_pkg::*;
#(
   parameter int KEY_SEL   = 1,
   parameter bit HOLD_EN   = 1'b0,
   parameter int NR_CYCLES = 50
) (
   input  logic            clk,
   input  logic            osc_run,
   input  logic [KEYS-1:0] key_n,
   input  logic            sec_tick,
   output logic            combo_low,
   output logic            key_fire
);
   localparam logic [KEYS-1:0] MASK = chord_mask(KEY_SEL);
   localparam int NR_W = $clog2(NR_CYCLES + 1);

   generate
      if (MASK == '0) begin : g_off
         logic unused_in;
         assign unused_in = ^{key_n, sec_tick, clk, osc_run};
         assign combo_low = 1'b0;
         assign key_fire  = 1'b0;
      end else begin : g_on
         logic [KEYS-1:0] s1, s2;
         logic [NR_W-1:0] nr_cnt;
         logic            nr_ok;

         always_ff @(posedge clk or negedge osc_run) begin
            if (!osc_run) begin
               s1 <= '1;
               s2 <= '1;
            end else begin
               s1 <= key_n;
               s2 <= s1;
            end
         end

         assign combo_low = ((~s2 & MASK) == MASK);

         always_ff @(posedge clk or negedge osc_run) begin
            if (!osc_run)                           nr_cnt <= '0;
            else if (!combo_low)                    nr_cnt <= '0;
            else if (nr_cnt != NR_W'(NR_CYCLES))    nr_cnt <= nr_cnt + NR_W'(1);
         end

         assign nr_ok = (nr_cnt == NR_W'(NR_CYCLES));

         if (HOLD_EN) begin : g_hold
            logic [1:0] hcnt;
            always_ff @(posedge clk or negedge osc_run) begin
               if (!osc_run)                                hcnt <= '0;
               else if (!combo_low)                         hcnt <= '0;
               else if (nr_ok && sec_tick && hcnt != 2'd2)  hcnt <= hcnt + 2'd1;
            end
            assign key_fire = combo_low & (hcnt == 2'd2);
         end else begin : g_direct
            logic unused_tick;
            assign unused_tick = sec_tick;
            assign key_fire    = combo_low & nr_ok;
         end
      end
   endgenerate
endmodule

// File: rtl/sysrst_hold.sv
module sysrst_hold (
   input  logic clk,
   input  logic rst_pin_n,
   input  logic ph2,
   input  logic key_fire,
   output logic sys_rst
);
   logic p1, p2;

   // pin synchroniser, cleared the moment the pin goes low
   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) begin
         p1 <= 1'b0;
         p2 <= 1'b0;
      end else begin
         p1 <= 1'b1;
         p2 <= p1;
      end
   end

   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n)      sys_rst <= 1'b1;
      else if (key_fire)   sys_rst <= 1'b1;
      else if (p2 && ph2)  sys_rst <= 1'b0;
   end
endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen
   import sysrst_pkg::*;
#(
   parameter int KEY_SEL   = 1,
   parameter bit HOLD_EN   = 1'b0,
   parameter int DIV_LOG2  = 15,
   parameter int NR_CYCLES = 50
) (
   input  logic            clk_lf,
   input  logic            osc_run,
   input  logic            rst_pin_n,
   input  logic [KEYS-1:0] key_n,
   output logic            sys_rst
);
   generate
      if (DIV_LOG2 < 3) begin : g_bad_div
         $error("sysrst_gen: DIV_LOG2 must be at least 3");
      end
      if (NR_CYCLES < 1) begin : g_bad_nr
         $error("sysrst_gen: NR_CYCLES must be at least 1");
      end
      if (KEY_SEL < 0 || KEY_SEL > 3) begin : g_bad_sel
         $error("sysrst_gen: KEY_SEL must be 0..3");
      end
   endgenerate

   logic ph2, sec_tick, combo_low, key_fire;

   sysrst_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk(clk_lf), .osc_run(osc_run), .ph2(ph2), .sec_tick(sec_tick)
   );

   sysrst_keyfilt #(.KEY_SEL(KEY_SEL), .HOLD_EN(HOLD_EN), .NR_CYCLES(NR_CYCLES)) u_keys (
      .clk(clk_lf), .osc_run(osc_run), .key_n(key_n), .sec_tick(sec_tick),
      .combo_low(combo_low), .key_fire(key_fire)
   );

   sysrst_hold u_hold (
      .clk(clk_lf), .rst_pin_n(rst_pin_n), .ph2(ph2), .key_fire(key_fire),
      .sys_rst(sys_rst)
   );
endmodule

// File: rtl/sysrst_gen_chk.sv
module sysrst_gen_chk (
   input logic clk,
   input logic osc_run,
   input logic rst_pin_n,
   input logic sys_rst,
   input logic ph2,
   input logic combo_low,
   input logic key_fire
);
   assert_pin_holds_R1: assert property (@(posedge clk) disable iff (!osc_run)
      !rst_pin_n |-> sys_rst);

   assert_release_phase_R2: assert property (@(posedge clk) disable iff (!osc_run)
      $fell(sys_rst) |-> ($past(ph2) && $past(rst_pin_n)));

   assert_no_release_off_phase_R2: assert property (@(posedge clk) disable iff (!osc_run)
      (sys_rst && !ph2) |=> sys_rst);

   assert_break_restarts_R7: assert property (@(posedge clk) disable iff (!osc_run)
      !combo_low |=> !key_fire);

   assert_key_sets_reset_R9: assert property (@(posedge clk) disable iff (!osc_run)
      key_fire |=> sys_rst);
endmodule

bind sysrst_gen sysrst_gen_chk u_chk (
   .clk(clk_lf), .osc_run(osc_run), .rst_pin_n(rst_pin_n), .sys_rst(sys_rst),
   .ph2(ph2), .combo_low(combo_low), .key_fire(key_fire)
);

// File: tb/sysrst_gen_tb.sv
`timescale 1ns/100ps
module sysrst_gen_tb;
   localparam int DIVL = 6;
   localparam int NR   = 5;
   localparam int QTR  = 1 << (DIVL - 2);

   logic clk = 1'b0;
   logic osc_run = 1'b0;
   logic pin_n = 1'b0;
   logic [3:0] keys = 4'hF;
   logic r_m1, r_m2, r_m3, r_off, r_hold;
   int   ecnt = 0;
   int   checks = 0, fails = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) ecnt <= osc_run ? ecnt + 1 : 0;

   sysrst_gen #(.KEY_SEL(1), .HOLD_EN(1'b0), .DIV_LOG2(DIVL), .NR_CYCLES(NR)) u_dut (
      .clk_lf(clk), .osc_run(osc_run), .rst_pin_n(pin_n), .key_n(keys), .sys_rst(r_m1));
   sysrst_gen #(.KEY_SEL(2), .HOLD_EN(1'b0), .DIV_LOG2(DIVL), .NR_CYCLES(NR)) u_dut_m2 (
      .clk_lf(clk), .osc_run(osc_run), .rst_pin_n(pin_n), .key_n(keys), .sys_rst(r_m2));
   sysrst_gen #(.KEY_SEL(3), .HOLD_EN(1'b0), .DIV_LOG2(DIVL), .NR_CYCLES(NR)) u_dut_m3 (
      .clk_lf(clk), .osc_run(osc_run), .rst_pin_n(pin_n), .key_n(keys), .sys_rst(r_m3));
   sysrst_gen #(.KEY_SEL(0), .HOLD_EN(1'b0), .DIV_LOG2(DIVL), .NR_CYCLES(NR)) u_dut_off (
      .clk_lf(clk), .osc_run(osc_run), .rst_pin_n(pin_n), .key_n(keys), .sys_rst(r_off));
   sysrst_gen #(.KEY_SEL(3), .HOLD_EN(1'b1), .DIV_LOG2(DIVL), .NR_CYCLES(NR)) u_dut_hold (
      .clk_lf(clk), .osc_run(osc_run), .rst_pin_n(pin_n), .key_n(keys), .sys_rst(r_hold));

   // {pattern[3:0], hold length[5:0]}
   localparam logic [9:0] VEC [9] = '{
      {4'b0000, 6'd6}, {4'b0000, 6'd5}, {4'b1000, 6'd6}, {4'b1100, 6'd7},
      {4'b0100, 6'd6}, {4'b1110, 6'd9}, {4'b0001, 6'd8}, {4'b1000, 6'd3},
      {4'b0010, 6'd6}
   };

   function automatic logic [3:0] exp_mask(input int sel);
      case (sel)
         1: return 4'b1111;
         2: return 4'b0111;
         3: return 4'b0011;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic exp_fire(input int sel, input logic [3:0] pat, input int len);
      logic [3:0] m = exp_mask(sel);
      return (m != 0) && ((~pat & m) == m) && (len >= NR + 1);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic negs(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_all_low(input string req);
      int n = 0;
      while ((r_m1 | r_m2 | r_m3 | r_off | r_hold) !== 1'b0 && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(req, r_m1 | r_m2 | r_m3 | r_off | r_hold, 1'b0);
   endtask

   // R2: measure release of u_dut after the pin rose at edge count rise_e
   task automatic check_release(input int rise_e);
      int n = 0;
      int k, d;
      while (r_m1 !== 1'b0 && n < 200) begin
         @(negedge clk);
         n++;
      end
      k = ecnt;
      d = k - rise_e;
      chk("R2 phase bit set on release edge", 1'(((k - 1) >> (DIVL - 2)) & 1), 1'b1);
      chk("R2 release delay window", (d >= 3) && (d <= QTR + 4), 1'b1);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int rise_e, dly;
      logic [3:0] pat;
      int len;

      // reset state: pin low holds reset (R1)
      negs(3);
      chk("R1 reset while pin low", r_m1, 1'b1);
      chk("R1 reset while pin low (disabled-key unit)", r_off, 1'b1);
      osc_run = 1'b1;
      negs(4);
      chk("R1 still held after osc start", r_m1, 1'b1);

      // first release, pin rises at phase 4 of a quarter (R2)
      pin_n = 1'b1;
      rise_e = ecnt;
      negs(2);
      chk("R2 no release before sync", r_m1, 1'b1);
      check_release(rise_e);
      wait_all_low("R2 all units released");

      // vector table: chords (R3, R4, R5)
      foreach (VEC[i]) begin
         pat = VEC[i][9:6];
         len = int'(VEC[i][5:0]);
         keys = pat;
         negs(len);
         keys = 4'hF;
         negs(2);
         chk($sformatf("R3 R5 mask1 vec%0d", i), r_m1, exp_fire(1, pat, len));
         chk($sformatf("R3 R5 mask2 vec%0d", i), r_m2, exp_fire(2, pat, len));
         chk($sformatf("R3 R5 mask3 vec%0d", i), r_m3, exp_fire(3, pat, len));
         chk($sformatf("R4 disabled vec%0d", i), r_off, 1'b0);
         chk($sformatf("R6 long-press not reached vec%0d", i), r_hold, 1'b0);
         wait_all_low("R9 release after chord ends");
      end

      // R5 exact latency on a held chord
      keys = 4'b0000;
      negs(NR + 2);
      chk("R5 not yet at edge NR+2", r_m1, 1'b0);
      negs(1);
      chk("R5 set at edge NR+3", r_m1, 1'b1);
      negs(40);
      chk("R9 held while chord held", r_m1, 1'b1);
      keys = 4'hF;
      wait_all_low("R9 released after chord");

      // R7 break: NR low, one high, NR low
      keys = 4'b0000;
      negs(NR);
      keys = 4'hF;
      negs(1);
      keys = 4'b0000;
      negs(NR);
      keys = 4'hF;
      negs(2);
      chk("R7 break restarts debounce", r_m1, 1'b0);
      wait_all_low("R7 idle");

      // R6 long-press and R7 on the hold counter
      keys = 4'b1100;
      negs(50);
      keys = 4'hF;
      negs(1);
      keys = 4'b1100;
      dly = 0;
      while (r_hold !== 1'b1 && dly < 300) begin
         @(negedge clk);
         dly++;
         if (dly == 40) chk("R6 R7 no long-press reset after break", r_hold, 1'b0);
      end
      chk("R6 long-press lower bound", dly >= (1 << DIVL), 1'b1);
      chk("R6 long-press upper bound", dly <= (2 << DIVL) + NR + 4, 1'b1);
      keys = 4'hF;
      wait_all_low("R9 long-press released");

      // R1 sub-cycle pin pulse
      @(negedge clk);
      #1 pin_n = 1'b0;
      #0.5 chk("R1 async assert on short pulse", r_m1, 1'b1);
      #0.5 pin_n = 1'b1;
      rise_e = ecnt;
      negs(2);
      chk("R1 short pulse held", r_m1, 1'b1);
      check_release(rise_e);
      wait_all_low("R2 idle after pulse");

      // R8 oscillator stopped: key path idle, counting restarts on start
      osc_run = 1'b0;
      keys = 4'b0000;
      negs(20);
      chk("R8 no key reset while osc stopped", r_m1, 1'b0);
      osc_run = 1'b1;
      negs(NR + 2);
      chk("R8 debounce counted from osc start", r_m1, 1'b0);
      negs(1);
      chk("R8 key reset after osc start", r_m1, 1'b1);
      keys = 4'hF;
      wait_all_low("R8 idle");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule